// File: doc/BRIEF.md
# Glitch Clock Insertion Generator

This block derives the clock of a target circuit from a fast oversampling clock. Outside of an armed event it produces a steady normal-rate clock of 32 fast ticks per period with a 16/16 duty cycle. When a trigger arrives, it counts a programmable number of normal periods. It then replaces the next two normal periods with one short period of programmable length followed by one complementary long period, so that the pair still lasts exactly 64 fast ticks. After that it returns to normal periods and pulses a done flag.

A characterisation run sweeps the short length downward across successive events until the target starts to fail. Each change of the short length asks the external clock multiplier to restart. The block drives a reset request to the multiplier and keeps it asserted until the multiplier reports lock again. While lock is absent, the target clock is parked low and triggers are refused.

Top module: `glitch_clk_gen`

## Requirements
- R1: After reset, `done_o` and `mult_rst_o` are 0, the block is idle, and `tclk_o` runs with normal periods (the reset value of the stored short length is 16).
- R2: Every period outside a glitch event is 32 fast ticks long, with 16 ticks high followed by 16 ticks low.
- R3: A trigger accepted during period P0 makes period P(ofs+1) the short period of S ticks, where ofs is `cyc_ofs_i` sampled with the trigger. The period right after it is the long one, of 64-S ticks, so the two together last 64 ticks.
- R4: Each glitched period starts high and stays high for floor(length/2) ticks, then goes low for the rest.
- R5: S is `short_w_i` (an unsigned 6-bit value) clamped to the range 2..31: any value below 2 gives 2 and any value above 31 gives 31.
- R6: `done_o` is a one-tick pulse, raised once per event, 31 ticks after the rising edge that opens the normal period following the long one, which is one tick before the next rising edge.
- R7: A trigger that arrives while an event is in progress is ignored. Each accepted trigger yields exactly one glitch pair.
- R8: While `lock_i` is 0, `tclk_o` is 0 from the next tick on, and a trigger is ignored.
- R9: When idle with lock high, a clamped `short_w_i` that differs from the stored length raises `mult_rst_o` from the next tick. The request is held for at least 4 ticks and then until `lock_i` is 1. A new raw value that clamps to the stored length raises no request.
- R10: If a length change and a trigger are seen in the same idle tick, the restart request wins and the trigger is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_fast_i | input | 1 | Fast oversampling clock, 32 ticks per normal period |
| rst_n_i | input | 1 | Asynchronous active-low reset |
| trig_i | input | 1 | Start-of-operation marker, sampled only when idle and locked |
| cyc_ofs_i | input | CW (8) | Number of full normal periods to wait before the short period |
| short_w_i | input | 6 | Requested short-period length in fast ticks (clamped) |
| lock_i | input | 1 | Lock indication from the external clock multiplier |
| tclk_o | output | 1 | Generated target clock |
| done_o | output | 1 | One-tick pulse after the event completes |
| mult_rst_o | output | 1 | Restart request to the external clock multiplier |

## Verification
Two things can collide when the block is idle: a length update that must start a multiplier restart, and a trigger that would arm an event. The bench changes `short_w_i` and pulses `trig_i` on the same tick. It then judges the outcome at the ports: `mult_rst_o` must rise, and over several hundred ticks no `done_o` pulse and no shortened period may appear. A second overlap, a repeated trigger during a running event, is judged by counting exactly one done pulse and one correctly placed short/long pair.

// File: rtl/glitch_clk_pkg.sv
package glitch_clk_pkg;
  typedef enum logic [2:0] {
    GS_IDLE,
    GS_RELOCK,
    GS_ARMED,
    GS_SHORT,
    GS_LONG,
    GS_TAIL
  } gstate_t;
endpackage

// File: rtl/glitch_width_clamp.sv
module glitch_width_clamp #(
  parameter int PW   = 6,
  parameter int MINV = 2,
  parameter int MAXV = 31
) (
  input  logic [PW-1:0] raw_i,
  output logic [PW-1:0] clamped_o
);
  always_comb begin
    if (raw_i < PW'(MINV))      clamped_o = PW'(MINV);
    else if (raw_i > PW'(MAXV)) clamped_o = PW'(MAXV);
    else                        clamped_o = raw_i;
  end
endmodule

// File: rtl/glitch_period_gen.sv
module glitch_period_gen #(
  parameter int PW = 6
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [PW-1:0] len_i,
  input  logic          lock_i,
  output logic          end_o,
  output logic          tclk_o
);
  logic [PW-1:0] cnt_q, cnt_d;
  logic          tclk_q, tclk_d;

  assign end_o = (cnt_q == len_i - PW'(1));

  always_comb begin
    cnt_d  = end_o ? '0 : cnt_q + PW'(1);
    tclk_d = lock_i && (cnt_q < (len_i >> 1));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      tclk_q <= 1'b0;
    end else begin
      cnt_q  <= cnt_d;
      tclk_q <= tclk_d;
    end
  end

  assign tclk_o = tclk_q;
endmodule

// File: rtl/glitch_seq_ctrl.sv
module glitch_seq_ctrl
  import glitch_clk_pkg::*;
#(
  parameter int PW      = 6,
  parameter int CW      = 8,
  parameter int NORM    = 32,
  parameter int MIN_RST = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          trig_i,
  input  logic          lock_i,
  input  logic [CW-1:0] ofs_i,
  input  logic [PW-1:0] width_i,
  input  logic          period_end_i,
  output gstate_t       state_o,
  output logic [PW-1:0] len_o,
  output logic          done_o,
  output logic          mult_rst_o
);
  localparam int RW = $clog2(MIN_RST + 1);
  localparam logic [PW:0] PAIR = (PW+1)'(2 * NORM);

  gstate_t       st_q, st_d;
  logic [CW-1:0] cyc_q, cyc_d;
  logic [PW-1:0] w_q, w_d;
  logic [RW-1:0] rc_q, rc_d;
  logic          done_q, done_d;

  always_comb begin
    st_d   = st_q;
    cyc_d  = cyc_q;
    w_d    = w_q;
    rc_d   = rc_q;
    done_d = 1'b0;
    case (st_q)
      GS_IDLE: begin
        if (lock_i && (width_i != w_q)) begin
          st_d = GS_RELOCK;
          w_d  = width_i;
          rc_d = '0;
        end else if (lock_i && trig_i) begin
          st_d  = GS_ARMED;
          cyc_d = ofs_i;
        end
      end
      GS_RELOCK: begin
        if ((rc_q >= RW'(MIN_RST - 1)) && lock_i) st_d = GS_IDLE;
        else if (rc_q < RW'(MIN_RST - 1))         rc_d = rc_q + RW'(1);
      end
      GS_ARMED: begin
        if (period_end_i) begin
          if (cyc_q == '0) st_d = GS_SHORT;
          else             cyc_d = cyc_q - CW'(1);
        end
      end
      GS_SHORT: if (period_end_i) st_d = GS_LONG;
      GS_LONG:  if (period_end_i) st_d = GS_TAIL;
      GS_TAIL: begin
        if (period_end_i) begin
          st_d   = GS_IDLE;
          done_d = 1'b1;
        end
      end
      default: st_d = GS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= GS_IDLE;
      cyc_q  <= '0;
      w_q    <= PW'(NORM / 2);
      rc_q   <= '0;
      done_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cyc_q  <= cyc_d;
      w_q    <= w_d;
      rc_q   <= rc_d;
      done_q <= done_d;
    end
  end

  always_comb begin
    case (st_q)
      GS_SHORT: len_o = w_q;
      GS_LONG:  len_o = PW'(PAIR - {1'b0, w_q});
      default:  len_o = PW'(NORM);
    endcase
  end

  assign state_o    = st_q;
  assign done_o     = done_q;
  assign mult_rst_o = (st_q == GS_RELOCK);
endmodule

// File: rtl/glitch_clk_gen.sv
module glitch_clk_gen
  import glitch_clk_pkg::*;
#(
  parameter int NORM_TICKS    = 32,
  parameter int CW            = 8,
  parameter int MIN_RST_TICKS = 4
) (
  input  logic                                clk_fast_i,
  input  logic                                rst_n_i,
  input  logic                                trig_i,
  input  logic [CW-1:0]                       cyc_ofs_i,
  input  logic [$clog2(2*NORM_TICKS)-1:0]     short_w_i,
  input  logic                                lock_i,
  output logic                                tclk_o,
  output logic                                done_o,
  output logic                                mult_rst_o
);
  localparam int PW = $clog2(2 * NORM_TICKS);

  logic [1:0]    rst_sync_q;
  logic          rst_n_s;
  logic [PW-1:0] width_c;
  logic [PW-1:0] len;
  logic          period_end;
  gstate_t       st;

  always_ff @(posedge clk_fast_i or negedge rst_n_i) begin
    if (!rst_n_i) rst_sync_q <= 2'b00;
    else          rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  glitch_width_clamp #(.PW(PW), .MINV(2), .MAXV(NORM_TICKS - 1)) u_clamp (
    .raw_i     (short_w_i),
    .clamped_o (width_c)
  );

  glitch_seq_ctrl #(.PW(PW), .CW(CW), .NORM(NORM_TICKS), .MIN_RST(MIN_RST_TICKS)) u_ctrl (
    .clk          (clk_fast_i),
    .rst_n        (rst_n_s),
    .trig_i       (trig_i),
    .lock_i       (lock_i),
    .ofs_i        (cyc_ofs_i),
    .width_i      (width_c),
    .period_end_i (period_end),
    .state_o      (st),
    .len_o        (len),
    .done_o       (done_o),
    .mult_rst_o   (mult_rst_o)
  );

  glitch_period_gen #(.PW(PW)) u_period (
    .clk    (clk_fast_i),
    .rst_n  (rst_n_s),
    .len_i  (len),
    .lock_i (lock_i),
    .end_o  (period_end),
    .tclk_o (tclk_o)
  );
endmodule

// File: rtl/glitch_clk_gen_chk.sv
module glitch_clk_gen_chk
  import glitch_clk_pkg::*;
#(
  parameter int PW   = 6,
  parameter int NORM = 32
) (
  input logic          clk,
  input logic          rst_n,
  input logic          lock,
  input logic          tclk,
  input logic          done,
  input logic          mrst,
  input gstate_t       st,
  input logic [PW-1:0] len,
  input logic          pend
);
  AST_PAIR_SUM: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_SHORT && pend) |=> (({1'b0, len} + {1'b0, $past(len)}) == (PW+1)'(2*NORM))); // R3
  AST_LEN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    (len >= PW'(2)) && ({1'b0, len} <= (PW+1)'(2*NORM - 2))); // R5
  AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R6
  AST_CLK_PARKED: assert property (@(posedge clk) disable iff (!rst_n)
    !lock |=> !tclk); // R8
  AST_NO_ARM_UNLOCKED: assert property (@(posedge clk) disable iff (!rst_n)
    (st == GS_IDLE && !lock) |=> (st == GS_IDLE)); // R8
  AST_RST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mrst && !lock) |=> mrst); // R9
endmodule

bind glitch_clk_gen glitch_clk_gen_chk #(.PW(PW), .NORM(NORM_TICKS)) u_chk (
  .clk  (clk_fast_i),
  .rst_n(rst_n_s),
  .lock (lock_i),
  .tclk (tclk_o),
  .done (done_o),
  .mrst (mult_rst_o),
  .st   (st),
  .len  (len),
  .pend (period_end)
);

// File: tb/test_glitch_clk_gen.sv
`timescale 1ns/1ps
module test_glitch_clk_gen;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       trig = 1'b0;
  logic [7:0] ofs = '0;
  logic [5:0] sw = 6'd16;
  logic       lock = 1'b1;
  logic       tclk, done, mrst;

  int n_chk = 0, n_fail = 0;
  int tick = 0, last_rise = 0, last_fall = 0, nrise = 0, ndone = 0;
  int done_idx = 0, done_gap = 0;
  int per [0:63];
  int hi  [0:63];
  logic tclk_prev = 1'b0;

  always #10 clk = ~clk;

  glitch_clk_gen i_glitch_clk_gen (
    .clk_fast_i(clk), .rst_n_i(rst_n), .trig_i(trig), .cyc_ofs_i(ofs),
    .short_w_i(sw), .lock_i(lock), .tclk_o(tclk), .done_o(done), .mult_rst_o(mrst)
  );

  always @(negedge clk) begin
    tick = tick + 1;
    if (tclk && !tclk_prev) begin
      if (nrise < 63) begin
        nrise = nrise + 1;
        per[nrise] = tick - last_rise;
        hi[nrise]  = last_fall - last_rise;
      end
      last_rise = tick;
    end
    if (!tclk && tclk_prev) last_fall = tick;
    if (done) begin
      ndone = ndone + 1;
      done_idx = nrise;
      done_gap = tick - last_rise;
    end
    tclk_prev = tclk;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  function automatic int clampw(input int raw);
    if (raw < 2) return 2;
    if (raw > 31) return 31;
    return raw;
  endfunction

  task automatic finish_sim();
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  endtask

  task automatic set_width(input int raw);
    @(negedge clk); sw = 6'(raw);
    repeat (2) @(negedge clk);
    while (mrst) @(negedge clk);
  endtask

  task automatic do_run(input int o, input int raw, input bit extra);
    int s = clampw(raw);
    int g = 0;
    set_width(raw);
    @(posedge tclk);
    repeat (2) @(negedge clk);
    trig = 1'b1; ofs = 8'(o); nrise = 0; ndone = 0;
    @(negedge clk); trig = 1'b0;
    if (extra) begin
      repeat (40) @(negedge clk);
      trig = 1'b1; ofs = 8'd0;
      @(negedge clk); trig = 1'b0;
    end
    while (!(ndone >= 1 && nrise >= o + 5) && g < 6000) begin
      @(negedge clk); g++;
    end
    repeat (40) @(negedge clk);
    for (int k = 1; k <= o + 1; k++) begin
      chk(per[k] == 32, "R2 normal period", per[k], 32);
      chk(hi[k] == 16, "R2 normal high", hi[k], 16);
    end
    chk(per[o+2] == s, "R3 short period", per[o+2], s);
    chk(per[o+3] == 64 - s, "R3 long period", per[o+3], 64 - s);
    chk(hi[o+2] == s / 2, "R4 short high", hi[o+2], s / 2);
    chk(hi[o+3] == (64 - s) / 2, "R4 long high", hi[o+3], (64 - s) / 2);
    chk(per[o+4] == 32 && per[o+5] == 32, "R2 after event", per[o+4], 32);
    chk(ndone == 1, extra ? "R7 one event" : "R6 done count", ndone, 1);
    chk(done_idx == o + 3, "R6 done position", done_idx, o + 3);
    chk(done_gap == 31, "R6 done offset", done_gap, 31);
  endtask

  initial begin
    int cnt;
    void'($urandom(32'h5eed));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    cnt = 0;
    repeat (100) begin @(negedge clk); if (mrst || done) cnt++; end
    chk(cnt == 0, "R1 quiet after reset", cnt, 0);
    chk(per[nrise] == 32 && hi[nrise] == 16, "R1 normal clock after reset", per[nrise], 32);

    do_run(0, 0, 1'b0);   // R5 low clamp, zero offset
    do_run(3, 63, 1'b0);  // R5 high clamp
    do_run(1, 20, 1'b1);  // R7 repeated trigger
    for (int i = 0; i < 8; i++) do_run(int'($urandom_range(6, 0)), int'($urandom_range(63, 0)), 1'b0);

    // R9: minimum restart length with lock high
    set_width(10);
    @(negedge clk); sw = 6'd12;
    cnt = 0;
    repeat (8) begin @(negedge clk); if (mrst) cnt++; end
    chk(cnt == 4, "R9 minimum restart ticks", cnt, 4);

    // R9: request held while lock is absent
    @(negedge clk); sw = 6'd14;
    @(negedge clk); lock = 1'b0;
    repeat (20) @(negedge clk);
    chk(mrst == 1'b1, "R9 held until lock", mrst, 1);
    lock = 1'b1;
    repeat (2) @(negedge clk);
    chk(mrst == 1'b0, "R9 released on lock", mrst, 0);

    // R9: raw change that clamps to the same length
    set_width(0);
    @(negedge clk); sw = 6'd1;
    cnt = 0;
    repeat (8) begin @(negedge clk); if (mrst) cnt++; end
    chk(cnt == 0, "R9 same clamped length no restart", cnt, 0);

    // R8: parked clock and refused trigger
    @(negedge clk); lock = 1'b0;
    repeat (2) @(negedge clk);
    cnt = 0; ndone = 0; nrise = 0;
    trig = 1'b1; @(negedge clk); trig = 1'b0;
    repeat (100) begin @(negedge clk); if (tclk) cnt++; end
    chk(cnt == 0, "R8 clock low without lock", cnt, 0);
    lock = 1'b1;
    repeat (400) @(negedge clk);
    chk(ndone == 0, "R8 trigger refused without lock", ndone, 0);
    chk(per[nrise] == 32, "R8 normal after lock", per[nrise], 32);

    // R10: length change and trigger in the same tick
    ndone = 0; cnt = 0; nrise = 0;
    @(negedge clk); sw = 6'd25; trig = 1'b1;
    @(negedge clk); trig = 1'b0;
    repeat (400) begin @(negedge clk); if (mrst) cnt++; end
    chk(cnt > 0, "R10 restart requested", cnt, 4);
    chk(ndone == 0, "R10 trigger dropped", ndone, 0);
    cnt = 0;
    for (int k = 2; k <= nrise; k++) if (per[k] != 32) cnt++;
    chk(cnt == 0, "R10 no glitch periods", cnt, 0);
    finish_sim();
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog actual=timeout expected=completion");
    finish_sim();
  end
endmodule